// File: doc/BRIEF.md
# Dual-Mode Pixel Array Sequencer

This block generates the digital control lines for a pixel array that alternates between two operating modes. In compute mode the whole array works as one multiply-accumulate element: the sequencer resets every pixel, then raises a single global compute line and clocks the column sense amplifiers through one precharge phase and one evaluate phase. Compute passes repeat for as long as the run input is held. When the downstream logic reports a detected object, the sequencer finishes the current pass and then captures a normal image.

In sensing mode the array is read one row at a time with correlated double sampling. Each row slot first samples the reset level through the first column sample switch. It then holds the row for a programmable exposure time and samples the exposed level through the second switch. A frame takes one slot per row. A pulse marks the final sample of the last row. A request to go back to compute mode that arrives during a frame is held until the current row slot has finished. The row count and the exposure length are loaded through a small configuration port that only accepts writes while the sequencer is idle.

Top module: `pixel_mode_sequencer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the sequencer is idle and every control output is low. The configuration resets to the full row count and a one-cycle exposure.
- R2: A write on cfg_we while idle stores cfg_rows_m1 (row count minus one) and cfg_exp_m1 (exposure cycles minus one). A write in any other state leaves the stored values unchanged.
- R3: A compute pass lasts three cycles. First comes one cycle with pix_rst high and comp_row low. Next comes a precharge cycle with comp_row and sa_clk high. Last comes an evaluate cycle with comp_row high and sa_clk low. row_sel is all zero for the whole pass.
- R4: When run is sampled high while idle, a compute pass starts in the next cycle. At the end of each pass, a new pass follows if run is high and no detection is pending; otherwise the sequencer returns to idle.
- R5: A detect sampled in any cycle of a compute pass, including its evaluate cycle, makes the next cycle after that evaluate the first slot of row 0. A detect sampled while idle or sensing has no effect.
- R6: A row slot has three parts. The first cycle drives pix_rst, pix_acc and cds_s1 high. Then follow cfg_exp_m1+1 exposure cycles with all four of pix_rst, pix_acc, cds_s1 and cds_s2 low. The last cycle drives pix_acc and cds_s2 high.
- R7: During sensing the sensing output is high, comp_row is low, and row_sel has exactly one bit high. Bit k of row_sel selects row k, and rows are visited in ascending order from row 0.
- R8: frame_done is high only in the second-sample cycle of row cfg_rows_m1. After that cycle a compute pass follows if run is high; otherwise the sequencer goes idle.
- R9: A resume request sampled during a row slot takes effect when the slot ends. The next cycle begins a compute pass, no further rows are read, and frame_done stays low unless that slot was the last row.
- R10: cds_s1 and cds_s2 are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Keep running compute passes |
| detect | input | 1 | Object detected; switch to sensing after the current pass |
| resume | input | 1 | Leave sensing at the end of the current row slot |
| cfg_we | input | 1 | Configuration write strobe, honoured only while idle |
| cfg_rows_m1 | input | $clog2(ROWS_MAX) | Number of rows per frame minus one |
| cfg_exp_m1 | input | EXP_W | Exposure cycles per row minus one |
| pix_rst | output | 1 | Pixel reset |
| row_sel | output | ROWS_MAX | One-hot row select lines |
| pix_acc | output | 1 | Pixel access to the column line |
| cds_s1 | output | 1 | Column sample switch for the reset level |
| cds_s2 | output | 1 | Column sample switch for the exposed level |
| comp_row | output | 1 | Global compute line for all pixels |
| sa_clk | output | 1 | Sense amplifier clock; high = precharge, low = evaluate |
| frame_done | output | 1 | Final sample of the last row of a frame |
| sensing | output | 1 | Sequencer is in sensing mode |

## Verification
A table-driven pattern first runs plain compute loops. It then runs a detection raised early in a pass, a detection raised in the evaluate cycle itself, and a detection raised during sensing, so a wrongly latched request shows up as an early frame. Resume requests placed mid-exposure separate deferred exits from immediate ones and from complete frames. Directed runs change the row count and exposure between frames and attempt a configuration write while busy. These runs distinguish a frame_done placed on the wrong row, an exposure counter that is off by one, and a write that leaks in outside idle. A reset applied in mid-pass shows that the outputs clear at once.

// File: rtl/pms_pkg.sv
package pms_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_CRST  = 3'd1,
      ST_CPRE  = 3'd2,
      ST_CEVAL = 3'd3,
      ST_SRST  = 3'd4,
      ST_SEXP  = 3'd5,
      ST_SRD   = 3'd6
   } pms_state_e;
endpackage

// File: rtl/pms_cfg.sv
module pms_cfg #(
   parameter int ROW_W = 4,
   parameter int EXP_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_en,
   input  logic [ROW_W-1:0] rows_m1_in,
   input  logic [EXP_W-1:0] exp_m1_in,
   output logic [ROW_W-1:0] rows_m1,
   output logic [EXP_W-1:0] exp_m1
);
   // Shadow registers; the caller gates load_en with the idle state.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rows_m1 <= '1;
         exp_m1  <= '0;
      end else if (load_en) begin
         rows_m1 <= rows_m1_in;
         exp_m1  <= exp_m1_in;
      end
   end
endmodule

// File: rtl/pms_rowdec.sv
module pms_rowdec #(
   parameter int ROWS_MAX = 16,
   localparam int ROW_W = $clog2(ROWS_MAX)
) (
   input  logic                en,
   input  logic [ROW_W-1:0]    idx,
   output logic [ROWS_MAX-1:0] onehot
);
   for (genvar k = 0; k < ROWS_MAX; k++) begin : g_line
      assign onehot[k] = en && (idx == ROW_W'(k));
   end
endmodule

// File: rtl/pms_fsm.sv
module pms_fsm
   import pms_pkg::*;
#(
   parameter int ROW_W = 4,
   parameter int EXP_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             detect,
   input  logic             resume,
   input  logic [ROW_W-1:0] rows_m1,
   input  logic [EXP_W-1:0] exp_m1,
   output pms_state_e       state,
   output logic [ROW_W-1:0] row_idx,
   output logic             last_row
);
   pms_state_e       nxt;
   logic [EXP_W-1:0] exp_cnt;
   logic             det_pend;
   logic             res_pend;
   logic             det_now;
   logic             res_now;

   assign last_row = (row_idx == rows_m1);
   assign det_now  = det_pend || detect;
   assign res_now  = res_pend || resume;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE:  nxt = run ? ST_CRST : ST_IDLE;
         ST_CRST:  nxt = ST_CPRE;
         ST_CPRE:  nxt = ST_CEVAL;
         ST_CEVAL: nxt = det_now ? ST_SRST : (run ? ST_CRST : ST_IDLE);
         ST_SRST:  nxt = ST_SEXP;
         ST_SEXP:  nxt = (exp_cnt == '0) ? ST_SRD : ST_SEXP;
         ST_SRD: begin
            if (last_row)     nxt = run ? ST_CRST : ST_IDLE;
            else if (res_now) nxt = ST_CRST;
            else              nxt = ST_SRST;
         end
         default:  nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         row_idx  <= '0;
         exp_cnt  <= '0;
         det_pend <= 1'b0;
         res_pend <= 1'b0;
      end else begin
         state    <= nxt;
         // Detection is held only across the first two cycles of a pass.
         det_pend <= (state == ST_CRST || state == ST_CPRE) && det_now;
         // Resume is held until the sampling cycle closes the slot.
         res_pend <= (state == ST_SRST || state == ST_SEXP) && res_now;
         if (state == ST_CEVAL)    row_idx <= '0;
         else if (state == ST_SRD) row_idx <= row_idx + 1'b1;
         if (state == ST_SRST)
            exp_cnt <= exp_m1;
         else if (state == ST_SEXP && exp_cnt != '0)
            exp_cnt <= exp_cnt - 1'b1;
      end
   end
endmodule

// File: rtl/pixel_mode_sequencer.sv
module pixel_mode_sequencer
   import pms_pkg::*;
#(
   parameter int ROWS_MAX = 16,
   parameter int EXP_W    = 12,
   localparam int ROW_W   = $clog2(ROWS_MAX)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  logic                detect,
   input  logic                resume,
   input  logic                cfg_we,
   input  logic [ROW_W-1:0]    cfg_rows_m1,
   input  logic [EXP_W-1:0]    cfg_exp_m1,
   output logic                pix_rst,
   output logic [ROWS_MAX-1:0] row_sel,
   output logic                pix_acc,
   output logic                cds_s1,
   output logic                cds_s2,
   output logic                comp_row,
   output logic                sa_clk,
   output logic                frame_done,
   output logic                sensing
);
   if (ROWS_MAX < 2 || (ROWS_MAX & (ROWS_MAX - 1)) != 0) begin : g_bad_rows
      $error("ROWS_MAX must be a power of two, at least 2");
   end
   if (EXP_W < 1) begin : g_bad_exp
      $error("EXP_W must be at least 1");
   end

   pms_state_e       state;
   logic [ROW_W-1:0] row_idx;
   logic             last_row;
   logic [ROW_W-1:0] rows_m1;
   logic [EXP_W-1:0] exp_m1;

   pms_cfg #(.ROW_W(ROW_W), .EXP_W(EXP_W)) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_en    (cfg_we && state == ST_IDLE),
      .rows_m1_in (cfg_rows_m1),
      .exp_m1_in  (cfg_exp_m1),
      .rows_m1    (rows_m1),
      .exp_m1     (exp_m1)
   );

   pms_fsm #(.ROW_W(ROW_W), .EXP_W(EXP_W)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .detect   (detect),
      .resume   (resume),
      .rows_m1  (rows_m1),
      .exp_m1   (exp_m1),
      .state    (state),
      .row_idx  (row_idx),
      .last_row (last_row)
   );

   assign sensing    = (state == ST_SRST) || (state == ST_SEXP) || (state == ST_SRD);
   assign pix_rst    = (state == ST_CRST) || (state == ST_SRST);
   assign pix_acc    = (state == ST_SRST) || (state == ST_SRD);
   assign cds_s1     = (state == ST_SRST);
   assign cds_s2     = (state == ST_SRD);
   assign comp_row   = (state == ST_CPRE) || (state == ST_CEVAL);
   assign sa_clk     = (state == ST_CPRE);
   assign frame_done = (state == ST_SRD) && last_row;

   pms_rowdec #(.ROWS_MAX(ROWS_MAX)) u_rowdec (
      .en     (sensing),
      .idx    (row_idx),
      .onehot (row_sel)
   );
endmodule

// File: rtl/pms_checker.sv
module pms_checker #(
   parameter int ROWS_MAX = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ROWS_MAX-1:0] row_sel,
   input logic                pix_rst,
   input logic                pix_acc,
   input logic                cds_s1,
   input logic                cds_s2,
   input logic                comp_row,
   input logic                sa_clk,
   input logic                frame_done,
   input logic                sensing
);
   assert_sample_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(cds_s1 && cds_s2));

   assert_row_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sensing |-> ($countones(row_sel) == 1));

   assert_no_compute_in_sense_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sensing |-> !comp_row);

   assert_compute_rows_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      comp_row |-> (row_sel == '0));

   assert_precharge_then_eval_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (comp_row && sa_clk) |=> (comp_row && !sa_clk));

   assert_first_sample_then_expose_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cds_s1 |=> (!pix_acc && !pix_rst && !cds_s1 && !cds_s2 && sensing));

   assert_done_on_second_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> (cds_s2 && pix_acc));
endmodule

bind pixel_mode_sequencer pms_checker #(.ROWS_MAX(ROWS_MAX)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .row_sel    (row_sel),
   .pix_rst    (pix_rst),
   .pix_acc    (pix_acc),
   .cds_s1     (cds_s1),
   .cds_s2     (cds_s2),
   .comp_row   (comp_row),
   .sa_clk     (sa_clk),
   .frame_done (frame_done),
   .sensing    (sensing)
);

// File: tb/pixel_mode_sequencer_bench.sv
module pixel_mode_sequencer_bench;
   localparam int ROWS_MAX = 4;
   localparam int EXP_W    = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run = 1'b0, detect = 1'b0, resume = 1'b0, cfg_we = 1'b0;
   logic [1:0] cfg_rows_m1 = 2'd1;
   logic [3:0] cfg_exp_m1 = 4'd1;
   logic [3:0] row_sel;
   logic       pix_rst, pix_acc, cds_s1, cds_s2, comp_row, sa_clk, frame_done, sensing;
   logic [7:0] flags;
   int         nchk = 0;
   int         nfail = 0;

   always #2 clk = ~clk;

   pixel_mode_sequencer #(.ROWS_MAX(ROWS_MAX), .EXP_W(EXP_W)) u_pixel_mode_sequencer (
      .clk(clk), .rst_n(rst_n), .run(run), .detect(detect), .resume(resume),
      .cfg_we(cfg_we), .cfg_rows_m1(cfg_rows_m1), .cfg_exp_m1(cfg_exp_m1),
      .pix_rst(pix_rst), .row_sel(row_sel), .pix_acc(pix_acc), .cds_s1(cds_s1),
      .cds_s2(cds_s2), .comp_row(comp_row), .sa_clk(sa_clk),
      .frame_done(frame_done), .sensing(sensing)
   );

   // flags = {pix_rst, pix_acc, cds_s1, cds_s2, comp_row, sa_clk, frame_done, sensing}
   assign flags = {pix_rst, pix_acc, cds_s1, cds_s2, comp_row, sa_clk, frame_done, sensing};

   // {run, detect, resume, cfg_we} applied this cycle, expected row_sel, expected flags.
   // Config: 2 rows, 2 exposure cycles. 80/0C/08 = compute pass, E1/01/51 = row slot, 53 = last sample.
   localparam int NV = 31;
   localparam logic [15:0] VEC [NV] = '{
      16'h1_0_00, 16'h8_0_00,                         // R2 load, R4 start
      16'h8_0_80, 16'h8_0_0C, 16'h8_0_08,             // R3 pass, loops (R4)
      16'hC_0_80, 16'h8_0_0C, 16'h8_0_08,             // R5 early detect
      16'h8_1_E1, 16'hC_1_01, 16'h8_1_01, 16'h8_1_51, // R6 row 0, detect ignored
      16'h8_2_E1, 16'h8_2_01, 16'h8_2_01, 16'h8_2_53, // R7 row 1, R8 done
      16'h8_0_80, 16'h8_0_0C, 16'h8_0_08,             // R5 no stale detect
      16'h8_0_80, 16'h8_0_0C, 16'hC_0_08,             // R5 detect in evaluate
      16'h8_1_E1, 16'hA_1_01, 16'h8_1_01, 16'h8_1_51, // R9 resume deferred
      16'h0_0_80, 16'h0_0_0C, 16'h0_0_08,             // R9 back to compute, R4 stop
      16'h4_0_00, 16'h0_0_00                          // R5 detect in idle ignored
   };

   function automatic string req_of(input logic [7:0] f);
      case (f)
         8'h80, 8'h0C, 8'h08: return "R3";
         8'hE1, 8'h01, 8'h51: return "R6";
         8'h53:               return "R8";
         default:             return "R4";
      endcase
   endfunction

   task automatic chk(input logic [3:0] r, input logic [7:0] f, input string req);
      nchk++;
      if (row_sel !== r || flags !== f) begin
         nfail++;
         $display("FAIL %s: row_sel=%b flags=%b expected row_sel=%b flags=%b",
                  req, row_sel, flags, r, f);
      end
   endtask

   task automatic step(input logic [3:0] in, input logic [3:0] r, input logic [7:0] f,
                       input string req);
      @(negedge clk);
      chk(r, f, req);
      {run, detect, resume, cfg_we} = in;
   endtask

   initial begin
      // R1: reset state
      @(negedge clk);
      chk(4'h0, 8'h00, "R1");
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++)
         step(VEC[i][15:12], VEC[i][11:8], VEC[i][7:0], req_of(VEC[i][7:0]));

      // R2: write while busy is ignored (rows stay 2, exposure stays 2)
      cfg_rows_m1 = 2'd0;
      cfg_exp_m1  = 4'd3;
      step(4'h8, 4'h0, 8'h00, "R4");
      step(4'h9, 4'h0, 8'h80, "R2");
      step(4'h8, 4'h0, 8'h0C, "R3");
      step(4'hC, 4'h0, 8'h08, "R5");
      step(4'h8, 4'h1, 8'hE1, "R6");
      step(4'h8, 4'h1, 8'h01, "R2");
      step(4'h8, 4'h1, 8'h01, "R2");
      step(4'h8, 4'h1, 8'h51, "R2");
      step(4'h8, 4'h2, 8'hE1, "R7");
      step(4'h8, 4'h2, 8'h01, "R6");
      step(4'h8, 4'h2, 8'h01, "R6");
      step(4'h0, 4'h2, 8'h53, "R8");
      step(4'h0, 4'h0, 8'h00, "R8");

      // R2: load 4 rows, 1 exposure cycle while idle
      cfg_rows_m1 = 2'd3;
      cfg_exp_m1  = 4'd0;
      step(4'h1, 4'h0, 8'h00, "R2");
      step(4'hC, 4'h0, 8'h00, "R4");
      step(4'h8, 4'h0, 8'h80, "R5");
      step(4'hC, 4'h0, 8'h0C, "R3");
      step(4'h8, 4'h0, 8'h08, "R5");
      for (int r = 0; r < 4; r++) begin
         step(4'h8, 4'(1 << r), 8'hE1, "R7");
         step(4'h8, 4'(1 << r), 8'h01, "R6");
         step((r == 3) ? 4'h8 : 4'h8, 4'(1 << r), (r == 3) ? 8'h53 : 8'h51, "R8");
      end
      step(4'h8, 4'h0, 8'h80, "R8");
      step(4'h8, 4'h0, 8'h0C, "R3");

      // R1: reset in the middle of a pass clears outputs at once
      rst_n = 1'b0;
      #1;
      chk(4'h0, 8'h00, "R1");
      run = 1'b0;
      @(negedge clk);
      chk(4'h0, 8'h00, "R1");
      rst_n = 1'b1;
      step(4'h0, 4'h0, 8'h00, "R1");

      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      #(4 * 200000);
      nchk++;
      nfail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule